// File: doc/BRIEF.md
# Gated Retriggerable Pulse Timer

This block is a clocked monostable pulse generator. A programmable count of clock cycles sets the pulse length. Five asynchronous control pins feed it:

- two active-low trigger pins;
- two active-high trigger pins;
- an active-low kill pin.

Each pin is brought into the clock domain through a flop chain. The block then forms a gated trigger condition from the synchronized pins. When that condition becomes true, the pulse timer starts, or restarts if a pulse is already running. While the pulse runs, the output `pulse` is high and `pulse_n` is low.

Each new entry into the trigger condition reloads the full programmed width. A pin toggled faster than that width therefore keeps the output high without a gap. Holding the kill pin low ends any pulse and blocks every trigger. Because the kill pin is part of the trigger condition, its release can fire a pulse when the other pins already meet the gating.

All pins are plain level controls, with no handshake. `width_cycles` is treated as a quasi-static setting. The timer reads it on the cycle that a trigger fires.

Top module: `gated_oneshot`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pulse` is 0 and `pulse_n` is 1.
- R2: The trigger condition is true when at least one of `trig_lo_a` and `trig_lo_b` is 0, both `trig_hi_a` and `trig_hi_b` are 1, and `kill_n` is 1. A pulse fires on every transition of the synchronized pins from the condition being false to it being true, so a falling low-side pin or a rising high-side pin can fire one.
- R3: A pin change first sampled by clock edge k reaches `pulse` at clock edge k+SYNC_STAGES. With the default of 2 stages, this is the third edge counted from the one that samples it.
- R4: A pulse that is neither retriggered nor killed stays high for exactly `width_cycles` clock cycles.
- R5: A `width_cycles` value of 0 gives a pulse of one clock cycle.
- R6: A trigger during a pulse reloads the timer, so the pulse ends `max(width_cycles,1)` cycles after the latest trigger. Triggers spaced closer than the width keep `pulse` high continuously.
- R7: Holding the trigger condition true produces no further pulse. Only a new entry into the condition fires.
- R8: A synchronized `kill_n` of 0 forces `pulse` to 0 on the next edge. Trigger pins toggled while it is low start nothing.
- R9: When `kill_n` rises while the other pins already satisfy the gating, that rise fires a full-width pulse.
- R10: If `kill_n` goes low in the same cycle that the other pins enter the gating, no pulse starts. No pulse starts when `kill_n` is later released after the gating has been removed.
- R11: `pulse_n` is always the complement of `pulse`.
- R12: A pin excursion that begins and ends between two rising clock edges is never sampled and has no effect on `pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_lo_a | input | 1 | Asynchronous active-low trigger pin A |
| trig_lo_b | input | 1 | Asynchronous active-low trigger pin B |
| trig_hi_a | input | 1 | Asynchronous active-high trigger pin A |
| trig_hi_b | input | 1 | Asynchronous active-high trigger pin B |
| kill_n | input | 1 | Asynchronous active-low kill pin, also part of the trigger gating |
| width_cycles | input | WIDTH_W | Pulse length in clock cycles (0 gives 1) |
| pulse | output | 1 | Pulse output, active high |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The bench builds the block with WIDTH_W = 8 and SYNC_STAGES = 2. The short widths keep every full pulse, retrigger chain and kill window within a few dozen cycles. With two stages, the trigger-to-output delay is a fixed three cycles from the cycle in which the bench drives a pin. Each expected pulse can therefore be predicted as an exact start cycle and length. The pin sequences cover both trigger polarities, merged retriggers, the kill pin both ending a pulse and firing one, and glitches shorter than a clock period.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Synchronized pin bundle; bit order fixes the synchronizer vector layout.
  typedef struct packed {
    logic kill_n;
    logic hi_b;
    logic hi_a;
    logic lo_b;
    logic lo_a;
  } pin_bundle_t;

  localparam int unsigned PIN_COUNT = $bits(pin_bundle_t);

  // Reset value of the synchronizer: every trigger and kill bit at 0.
  // This leaves the trigger condition false, because the high-side pins read 0.
  localparam pin_bundle_t PIN_RESET = '0;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned N_BITS  = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [N_BITS-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_BITS-1:0] async_in,
  output logic [N_BITS-1:0] sync_out
);

  logic [N_BITS-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/oneshot_trigger.sv
module oneshot_trigger
  import oneshot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pin_bundle_t pins,
  output logic        fire
);

  logic cond;
  logic cond_q;

  // Gate: any low-side pin asserted, both high-side pins asserted, kill released.
  always_comb begin
    cond = (~pins.lo_a | ~pins.lo_b) & pins.hi_a & pins.hi_b & pins.kill_n;
  end

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= cond;
  end

  // Only the entry into the condition counts.
  assign fire = cond & ~cond_q;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kill,
  input  logic               fire,
  input  logic [WIDTH_W-1:0] width,
  output logic               active,
  output logic [WIDTH_W-1:0] remain
);

  logic [WIDTH_W-1:0] eff_width;
  logic [WIDTH_W-1:0] reload;

  always_comb begin
    eff_width = (width == '0) ? WIDTH_W'(1) : width;
    reload    = eff_width - WIDTH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (kill) begin
      active <= 1'b0;
      remain <= '0;
    end else if (fire) begin
      active <= 1'b1;
      remain <= reload;
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - WIDTH_W'(1);
    end
  end

endmodule

// File: rtl/gated_oneshot.sv
module gated_oneshot
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_lo_a,
  input  logic               trig_lo_b,
  input  logic               trig_hi_a,
  input  logic               trig_hi_b,
  input  logic               kill_n,
  input  logic [WIDTH_W-1:0] width_cycles,
  output logic               pulse,
  output logic               pulse_n
);

  pin_bundle_t        raw_pins;
  logic [PIN_COUNT-1:0] synced_vec;
  pin_bundle_t        sync_pins;
  logic               fire;
  logic               kill_s;
  logic               run;
  logic [WIDTH_W-1:0] tmr_cnt;

  always_comb begin
    raw_pins.lo_a   = trig_lo_a;
    raw_pins.lo_b   = trig_lo_b;
    raw_pins.hi_a   = trig_hi_a;
    raw_pins.hi_b   = trig_hi_b;
    raw_pins.kill_n = kill_n;
  end

  oneshot_sync #(
    .N_BITS (PIN_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RESET)
  ) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_in(raw_pins),
    .sync_out(synced_vec)
  );

  assign sync_pins = pin_bundle_t'(synced_vec);
  assign kill_s    = ~sync_pins.kill_n;

  oneshot_trigger trig_i (
    .clk (clk),
    .rst (rst),
    .pins(sync_pins),
    .fire(fire)
  );

  oneshot_timer #(
    .WIDTH_W(WIDTH_W)
  ) tmr_i (
    .clk   (clk),
    .rst   (rst),
    .kill  (kill_s),
    .fire  (fire),
    .width (width_cycles),
    .active(run),
    .remain(tmr_cnt)
  );

  assign pulse   = run;
  assign pulse_n = ~run;

endmodule

// File: rtl/gated_oneshot_chk.sv
module gated_oneshot_chk #(
  parameter int unsigned WIDTH_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               pulse,
  input logic               pulse_n,
  input logic               kill_s,
  input logic               fire,
  input logic [WIDTH_W-1:0] tmr_cnt
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !pulse);

  // R11
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_n == !pulse);

  // R8
  kill_ends_chk: assert property (@(posedge clk) disable iff (rst)
    kill_s |=> !pulse);

  // R10
  kill_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    kill_s |-> !fire);

  // R2
  fire_starts_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse);

  // R7
  single_fire_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // R4
  expiry_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && tmr_cnt == '0 && !fire && !kill_s) |=> !pulse);

endmodule

bind gated_oneshot gated_oneshot_chk #(.WIDTH_W(WIDTH_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .pulse  (pulse),
  .pulse_n(pulse_n),
  .kill_s (kill_s),
  .fire   (fire),
  .tmr_cnt(tmr_cnt)
);

// File: tb/gated_oneshot_tb_top.sv
module gated_oneshot_tb_top;

  localparam int unsigned WIDTH_W = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int LAT = SYNC_STAGES + 1;   // from drive cycle to first high sample

  typedef struct {
    int    start;
    int    len;
    string tag;
  } exp_pulse_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_lo_a = 1'b1;
  logic trig_lo_b = 1'b1;
  logic trig_hi_a = 1'b1;
  logic trig_hi_b = 1'b1;
  logic kill_n = 1'b1;
  logic [WIDTH_W-1:0] width_cycles = 8'd5;
  logic pulse;
  logic pulse_n;

  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;
  exp_pulse_t exp_q[$];

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  gated_oneshot #(
    .WIDTH_W    (WIDTH_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .trig_lo_a   (trig_lo_a),
    .trig_lo_b   (trig_lo_b),
    .trig_hi_a   (trig_hi_a),
    .trig_hi_b   (trig_hi_b),
    .kill_n      (kill_n),
    .width_cycles(width_cycles),
    .pulse       (pulse),
    .pulse_n     (pulse_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_pulse(input int start, input int len, input string tag);
    exp_pulse_t e;
    e.start = start;
    e.len   = len;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  // Monitor: measures pulses and compares them against the scoreboard queue.
  bit in_pulse = 1'b0;
  int rise_cyc = 0;
  int run_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      // R11
      check(pulse_n === ~pulse, "R11", int'(pulse_n), int'(~pulse));
      if (pulse && !in_pulse) begin
        in_pulse = 1'b1;
        rise_cyc = cyc;
        run_len  = 1;
      end else if (pulse) begin
        run_len++;
      end else if (in_pulse) begin
        in_pulse = 1'b0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7/R8/R10/R12 unexpected pulse", rise_cyc, -1);
        end else begin
          exp_pulse_t e;
          e = exp_q.pop_front();
          check(rise_cyc == e.start, {e.tag, " start"}, rise_cyc, e.start);
          check(run_len == e.len, {e.tag, " length"}, run_len, e.len);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int c;
    wait_cyc(4);
    // R1: outputs idle during reset
    check(pulse == 1'b0 && pulse_n == 1'b1, "R1 in reset", int'(pulse), 0);
    rst = 1'b0;
    wait_cyc(1);
    check(pulse == 1'b0 && pulse_n == 1'b1, "R1 after reset", int'(pulse), 0);
    wait_cyc(5);

    // R2/R3/R4: falling low-side pin, width 5
    width_cycles = 8'd5;
    c = cyc;
    trig_lo_a = 1'b0;
    expect_pulse(c + LAT, 5, "R4");
    wait_cyc(LAT - 1);
    check(pulse == 1'b0, "R3 not yet", int'(pulse), 0);
    wait_cyc(1);
    check(pulse == 1'b1, "R3 latency", int'(pulse), 1);

    // R7: condition held static, no second pulse
    wait_cyc(25);
    check(pulse == 1'b0, "R7 static hold", int'(pulse), 0);

    // R2: rising high-side pin fires
    trig_lo_a = 1'b1;
    trig_lo_b = 1'b0;
    trig_hi_b = 1'b0;
    wait_cyc(6);
    width_cycles = 8'd7;
    c = cyc;
    trig_hi_b = 1'b1;
    expect_pulse(c + LAT, 7, "R2 rising high-side");
    wait_cyc(15);
    trig_lo_b = 1'b1;
    wait_cyc(6);

    // R5: width zero gives one cycle
    width_cycles = 8'd0;
    c = cyc;
    trig_lo_a = 1'b0;
    expect_pulse(c + LAT, 1, "R5");
    wait_cyc(8);
    trig_lo_a = 1'b1;
    wait_cyc(6);

    // R6: single retrigger extends to width after latest trigger
    width_cycles = 8'd6;
    c = cyc;
    trig_lo_a = 1'b0;
    wait_cyc(3);
    trig_lo_a = 1'b1;
    wait_cyc(1);
    trig_lo_a = 1'b0;
    expect_pulse(c + LAT, 4 + 6, "R6 retrigger");
    wait_cyc(20);
    trig_lo_a = 1'b1;
    wait_cyc(6);

    // R6: repeated retriggers every 3 cycles hold the output high
    c = cyc;
    trig_lo_a = 1'b0;
    for (int i = 0; i < 4; i++) begin
      wait_cyc(2);
      trig_lo_a = 1'b1;
      wait_cyc(1);
      trig_lo_a = 1'b0;
    end
    expect_pulse(c + LAT, 12 + 6, "R6 continuous");
    wait_cyc(25);
    trig_lo_a = 1'b1;
    wait_cyc(6);

    // R8: kill ends a running pulse
    width_cycles = 8'd20;
    c = cyc;
    trig_lo_a = 1'b0;
    wait_cyc(5);
    kill_n = 1'b0;
    expect_pulse(c + LAT, 5, "R8 kill");
    wait_cyc(10);
    // R8: toggles during kill start nothing
    trig_lo_a = 1'b1;
    wait_cyc(4);
    trig_lo_a = 1'b0;
    wait_cyc(10);
    check(pulse == 1'b0, "R8 held off", int'(pulse), 0);

    // R9: kill release with gating met fires
    c = cyc;
    kill_n = 1'b1;
    expect_pulse(c + LAT, 20, "R9");
    wait_cyc(30);
    trig_lo_a = 1'b1;
    wait_cyc(6);

    // R10: kill and gating arrive together
    kill_n = 1'b0;
    trig_lo_a = 1'b0;
    wait_cyc(10);
    trig_lo_a = 1'b1;
    wait_cyc(5);
    kill_n = 1'b1;
    wait_cyc(10);
    check(pulse == 1'b0, "R10", int'(pulse), 0);

    // R12: glitch between clock edges is not seen
    trig_lo_a = 1'b0;
    #1;
    trig_lo_a = 1'b1;
    wait_cyc(10);
    check(pulse == 1'b0, "R12", int'(pulse), 0);

    // every predicted pulse was observed
    check(exp_q.size() == 0 && !in_pulse, "R2 all pulses seen", exp_q.size(), 0);
    finish_run();
  end

endmodule